// File: doc/BRIEF.md
# Prescaled Reference-Match Timer

This block is a 16-bit up-counting timer behind a small byte-addressed register window. A prescaler divides the system clock by a programmable factor of 1 to 256. A selectable extra divide-by-16 stretches the period further. Each prescaler expiry advances the counter by one. When the counter holds the reference value at a tick, the reference event flag sets. In restart mode the counter then returns to zero, so the timer produces a periodic event every (reference + 1) ticks.

Software enables the timer through bit 0 of the mode register. It programs the period through the reference register, and it may preload the counter directly. Software acknowledges events by writing ones to the event register. A level interrupt is raised while the reference flag is set and the interrupt enable bit in the mode register is set. Clearing the enable bit of an enabled timer acts as a software reset of its configuration.

Top module: `refmatch_timer`

## Requirements
- R1: After reset the mode, reference, capture, counter and event registers all read zero and `irq` is low.
- R2: Register offsets are mode 0x00, reference 0x04, capture 0x08, counter 0x0C and event 0x11. Reads are combinational. Any other offset reads zero, and a write to any other offset changes nothing.
- R3: With mode bit 0 set, the counter advances once every (P+1) clocks, where P is mode bits 15:8. When mode bits 2:1 equal 2, the period is multiplied by 16. Every other value of bits 2:1 adds no divide. The first advance comes (P+1) clocks, or 16·(P+1) clocks, after the enabling write.
- R4: A tick that finds the counter equal to the reference sets event bit 1. With mode bit 3 set, that tick returns the counter to zero. With bit 3 clear, the counter keeps incrementing.
- R5: While mode bit 0 is clear, the counter and prescaler stay at zero, a counter write has no effect, and no event sets.
- R6: `irq` is high exactly when mode bit 4 and event bit 1 are both set.
- R7: A write to the event register clears each event bit written as one and leaves bits written as zero unchanged.
- R8: Writing the mode register with bit 0 clear while bit 0 is set clears both the mode and reference registers. The same write while bit 0 is already clear stores the written value.
- R9: A counter write loads the written value, and counting continues from it. A mode or reference write restarts the prescaler from zero.
- R10: The capture register is a plain read/write register, and event bit 0 never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- the counter and prescaler stay frozen while the timer is disabled;
- the reference flag only rises after a tick that found the counter at the reference value;
- a restart-mode match always brings the counter back to zero;
- a one written to the event register clears the flag;
- disabling an enabled timer wipes its mode and reference registers.

Other behaviour can only be shown by the bench's scenarios. This covers the exact tick period for several prescale values with and without the extra divide, and the prescaler restart after a reference write. It also covers counter preloading, interrupt gating through the enable bit, and the register map with its unmapped offsets.

// File: rtl/refmatch_pkg.sv
package refmatch_pkg;
  localparam logic [4:0] OFS_MODE  = 5'h00;
  localparam logic [4:0] OFS_REF   = 5'h04;
  localparam logic [4:0] OFS_CAP   = 5'h08;
  localparam logic [4:0] OFS_COUNT = 5'h0C;
  localparam logic [4:0] OFS_EVENT = 5'h11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_REF, SEL_CAP, SEL_COUNT, SEL_EVENT
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrRef;
    logic    wrCap;
    logic    wrCount;
    logic    wrEvent;
    regSel_e rdSel;
  } tmrStrobe_t;
endpackage

// File: rtl/refmatch_ctrl.sv
module refmatch_ctrl
  import refmatch_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output tmrStrobe_t        strb
);
  logic [4:0] ofs;
  assign ofs = 5'(addr);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    case (ofs)
      OFS_MODE:  begin strb.rdSel = SEL_MODE;  strb.wrMode  = wrEn; end
      OFS_REF:   begin strb.rdSel = SEL_REF;   strb.wrRef   = wrEn; end
      OFS_CAP:   begin strb.rdSel = SEL_CAP;   strb.wrCap   = wrEn; end
      OFS_COUNT: begin strb.rdSel = SEL_COUNT; strb.wrCount = wrEn; end
      OFS_EVENT: begin strb.rdSel = SEL_EVENT; strb.wrEvent = wrEn; end
      default:   strb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/refmatch_dp.sv
module refmatch_dp
  import refmatch_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int DIV_LOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);
  localparam int MODE_W = 8 + PRE_W;
  localparam int DIV_W  = PRE_W + DIV_LOG;

  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0]  refQ, capQ, countQ;
  logic [DIV_W-1:0]  preQ, preLimit;
  logic              evtRefQ;
  logic              enable, divSel, preRestart, tick, match, wipe;
  logic [PRE_W-1:0]  preVal;

  assign enable     = modeQ[0];
  assign divSel     = (modeQ[2:1] == 2'd2);
  assign preVal     = modeQ[MODE_W-1:8];
  assign preLimit   = divSel ? {preVal, {DIV_LOG{1'b1}}}
                             : {{DIV_LOG{1'b0}}, preVal};
  assign preRestart = strb.wrMode | strb.wrRef;
  assign tick       = enable & (preQ == preLimit) & ~preRestart;
  assign match      = tick & (countQ == refQ);
  assign wipe       = strb.wrMode & modeQ[0] & ~wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) preQ <= '0;
    else if (!enable || preRestart || preQ == preLimit) preQ <= '0;
    else preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) countQ <= '0;
    else if (strb.wrCount) countQ <= wrData;
    else if (tick) countQ <= (match && modeQ[3]) ? '0 : countQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      refQ  <= '0;
      capQ  <= '0;
    end else begin
      if (strb.wrMode) modeQ <= wipe ? '0 : wrData[MODE_W-1:0];
      if (wipe) refQ <= '0;
      else if (strb.wrRef) refQ <= wrData;
      if (strb.wrCap) capQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtRefQ <= 1'b0;
    else if (match) evtRefQ <= 1'b1;
    else if (strb.wrEvent && wrData[1]) evtRefQ <= 1'b0;
  end

  assign irq = modeQ[4] & evtRefQ;

  always_comb begin
    case (strb.rdSel)
      SEL_MODE:  rdData = CNT_W'(modeQ);
      SEL_REF:   rdData = refQ;
      SEL_CAP:   rdData = capQ;
      SEL_COUNT: rdData = countQ;
      SEL_EVENT: rdData = {{(CNT_W-2){1'b0}}, evtRefQ, 1'b0};
      default:   rdData = '0;
    endcase
  end

  // R5: disabled timer keeps counter and prescaler frozen at zero
  a_r5_held_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ[0] && $past(!modeQ[0])) |-> (countQ == '0 && preQ == '0));

  // R4: the reference flag only rises after a matching tick
  a_r4_flag_on_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtRefQ) |-> $past(modeQ[0] && countQ == refQ));

  // R4: restart mode returns the counter to zero after a match
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countQ == refQ && modeQ[3] && !strb.wrCount) |=> (countQ == '0));

  // R7: writing one to the reference event bit clears it
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEvent && wrData[1] && !match) |=> !evtRefQ);

  // R8: disabling an enabled timer wipes mode and reference
  a_r8_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMode && modeQ[0] && !wrData[0]) |=> (modeQ == '0 && refQ == '0));
endmodule

// File: rtl/refmatch_timer.sv
module refmatch_timer
  import refmatch_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int DIV_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  tmrStrobe_t strb;

  refmatch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  refmatch_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_LOG(DIV_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/refmatch_timer_bench.sv
module refmatch_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refmatch_timer u_refmatch_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {isWrite, offset, data, expected read}
  localparam int NV = 13;
  localparam logic [37:0] VECS [NV] = '{
    {1'b1, 5'h04, 16'h1234, 16'h0000},
    {1'b0, 5'h04, 16'h0000, 16'h1234},
    {1'b1, 5'h08, 16'hBEEF, 16'h0000},
    {1'b0, 5'h08, 16'h0000, 16'hBEEF},
    {1'b1, 5'h00, 16'h0100, 16'h0000},
    {1'b0, 5'h00, 16'h0000, 16'h0100},
    {1'b1, 5'h02, 16'hFFFF, 16'h0000},
    {1'b0, 5'h02, 16'h0000, 16'h0000},
    {1'b0, 5'h04, 16'h0000, 16'h1234},
    {1'b0, 5'h08, 16'h0000, 16'hBEEF},
    {1'b0, 5'h0C, 16'h0000, 16'h0000},
    {1'b0, 5'h11, 16'h0000, 16'h0000},
    {1'b0, 5'h1F, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] refv, input logic [15:0] modev);
    wr(5'h00, 16'h0000);
    wr(5'h11, 16'h0003);
    wr(5'h04, refv);
    wr(5'h00, modev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    rd(5'h00, v); chk("R1 mode", v, 16'h0);
    rd(5'h04, v); chk("R1 ref", v, 16'h0);
    rd(5'h08, v); chk("R1 cap", v, 16'h0);
    rd(5'h0C, v); chk("R1 count", v, 16'h0);
    rd(5'h11, v); chk("R1 event", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 register map table (also R10 capture read/write)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][37]) wr(VECS[i][36:32], VECS[i][31:16]);
      else begin
        rd(VECS[i][36:32], v);
        chk("R2 map", v, VECS[i][15:0]);
      end
    end

    // R5 disabled: counter write and time have no effect
    wr(5'h0C, 16'h0007);
    idle(10);
    rd(5'h0C, v); chk("R5 count held", v, 16'h0);

    // R3 P=0 no extra divide
    setup(16'hFFFF, 16'h0001);
    idle(7);
    rd(5'h0C, v); chk("R3 P0", v, 16'd7);
    // R3 P=2
    setup(16'hFFFF, 16'h0201);
    idle(10);
    rd(5'h0C, v); chk("R3 P2", v, 16'd3);
    // R3 clock source 1: no extra divide
    setup(16'hFFFF, 16'h0103);
    idle(10);
    rd(5'h0C, v); chk("R3 src1", v, 16'd5);
    // R3 clock source 2: extra divide by 16, P=1 -> period 32
    setup(16'hFFFF, 16'h0105);
    idle(95);
    rd(5'h0C, v); chk("R3 div16 before", v, 16'd2);
    idle(1);
    rd(5'h0C, v); chk("R3 div16 edge", v, 16'd3);

    // R9 prescaler restart on reference write, P=3
    setup(16'hFFFF, 16'h0301);
    idle(2);
    wr(5'h04, 16'hFFFF);
    idle(3);
    rd(5'h0C, v); chk("R9 pre restart", v, 16'd0);
    idle(1);
    rd(5'h0C, v); chk("R9 pre restart tick", v, 16'd1);
    // R9 counter load
    setup(16'hFFFF, 16'h0001);
    wr(5'h0C, 16'h0100);
    rd(5'h0C, v); chk("R9 load", v, 16'h0100);
    idle(5);
    rd(5'h0C, v); chk("R9 load count", v, 16'h0105);

    // R4 restart mode, ref=3, irq enabled (R6)
    setup(16'h0003, 16'h0019);
    idle(3);
    rd(5'h0C, v); chk("R4 at ref", v, 16'd3);
    chk("R6 irq low before match", {15'b0, irq}, 16'h0);
    idle(1);
    rd(5'h0C, v); chk("R4 restart zero", v, 16'd0);
    rd(5'h11, v); chk("R4 flag set", v, 16'h0002);
    chk("R6 irq high", {15'b0, irq}, 16'h1);

    // R4 no restart: keeps counting past reference
    setup(16'h0002, 16'h0001);
    idle(3);
    rd(5'h0C, v); chk("R4 no restart count", v, 16'd3);
    rd(5'h11, v); chk("R4 no restart flag", v, 16'h0002);
    chk("R6 irq gated off", {15'b0, irq}, 16'h0);
    wr(5'h00, 16'h0011);
    chk("R6 irq after enable", {15'b0, irq}, 16'h1);

    // R7 write-one-to-clear
    wr(5'h11, 16'h0001);
    rd(5'h11, v); chk("R7 zero bits kept", v, 16'h0002);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); chk("R7 cleared", v, 16'h0000);
    chk("R7 irq low", {15'b0, irq}, 16'h0);

    // R10 event bit 0 never sets
    setup(16'h0000, 16'h0009);
    idle(5);
    rd(5'h11, v); chk("R10 event bit0", v & 16'h0001, 16'h0);

    // R8 wipe on disable of an enabled timer
    setup(16'h0055, 16'h0101);
    wr(5'h00, 16'h0200);
    rd(5'h00, v); chk("R8 mode wiped", v, 16'h0);
    rd(5'h04, v); chk("R8 ref wiped", v, 16'h0);
    wr(5'h00, 16'h0200);
    rd(5'h00, v); chk("R8 store while off", v, 16'h0200);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule